// File: doc/BRIEF.md
# I2C Ten-Bit Addressed Slave Front End

This block is the slave side of an I2C port that answers to a ten-bit own address. It watches already-synchronised SCL and SDA samples and finds START, repeated START and STOP. It drives only two open-drain requests: a pull-down on SDA, used for acknowledges and for transmitted data bits, and a hold-low on SCL, used to stretch the clock. A host sits beside it and owns one receive byte register and one transmit byte register.

Selection happens in two steps. The first address byte has the form `11110 A9 A8 RW` in bits 7..0. The block ACKs it when A9..A8 match its own address and RW is 0. Several slaves may ACK this byte, so the block does not treat that ACK as selection. The block is selected only when the second byte also matches own-address bits 7..0. After that it receives data bytes. A later repeated START whose first byte carries RW=1 switches the selected block to transmit, and the low address byte is not sent again.

At the end of every byte the block holds SCL low until the buffer it needs has been serviced. In receive it waits for the receive register to be free. In transmit it waits for the transmit register to be full. A STOP ends the selection.

Top module: `i2c10_slave`

## Requirements
- R1: The block drives neither SDA nor SCL while `master_en_i` is 1 or `mode10_en_i` is 0, even when a matching address is sent.
- R2: After START, a first byte whose bits 7..3 equal 11110, whose bits 2..1 equal `own_addr_i[9:8]` and whose bit 0 is 0 is ACKed. Any other prefix or upper-bit value gets no ACK.
- R3: An ACKed first byte alone does not select the block. If the second byte differs from `own_addr_i[7:0]`, that byte gets no ACK, `busy_o` stays 0 and `start_o` does not pulse.
- R4: A second byte equal to `own_addr_i[7:0]` is ACKed. On that match `busy_o` becomes 1, `dir_tx_o` becomes 0 and `start_o` pulses for one cycle.
- R5: While selected for receive, each data byte (MSB first) is copied to `rx_data_o` and `rx_full_o` is set. `byte_end_o` pulses and the byte is ACKed.
- R6: If `rx_full_o` is still 1 when a data byte completes, `scl_hold_o` stays 1 and `rx_data_o` keeps the old byte. This lasts until `rx_read_i` is pulsed. The new byte is then copied and ACKed.
- R7: If the block is selected, a repeated START with first byte `11110 A9 A8 1` is ACKed. `dir_tx_o` becomes 1 and `start_o` pulses. The transmit register is then sent MSB first.
- R8: A first byte with RW=1 gets no ACK unless a full ten-bit match has happened since the last STOP.
- R9: `tx_empty_o` is 1 after reset and goes to 0 on `tx_load_i`. It returns to 1 each time a byte is taken for sending. When a byte is needed and `tx_empty_o` is 1, `scl_hold_o` stays 1 until `tx_load_i`.
- R10: After a transmitted byte gets a NACK from the master, the block drives no SDA low until the next START or STOP.
- R11: A STOP clears `busy_o` and `dir_tx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master mode on; the slave logic stays inactive |
| mode10_en_i | input | 1 | Enables ten-bit slave addressing |
| own_addr_i | input | 10 | Own ten-bit slave address |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| scl_hold_o | output | 1 | 1 holds SCL low (clock stretch) |
| tx_data_i | input | 8 | Byte the host writes into the transmit register |
| tx_load_i | input | 1 | Strobe that writes `tx_data_i` |
| rx_read_i | input | 1 | Strobe: the host has taken the receive byte |
| rx_data_o | output | 8 | Receive register |
| start_o | output | 1 | One-cycle pulse when the block becomes addressed |
| byte_end_o | output | 1 | One-cycle pulse at the end of each data byte |
| rx_full_o | output | 1 | Receive register holds an unread byte |
| tx_empty_o | output | 1 | Transmit register needs a new byte |
| busy_o | output | 1 | Block is selected in a transfer |
| dir_tx_o | output | 1 | 1 = transmitting, 0 = receiving |

## Verification
The bench sends every upper-bit value under the correct prefix and under two wrong prefixes. A block that decoded only the two address bits would ACK the bad prefixes. It then sends several wrong low bytes after an ACKed first byte; a block that treated the first ACK as selection would raise `busy_o` or take data. A read request after STOP checks that a stale selection cannot turn the block into a transmitter. Back-to-back unread bytes and an empty transmit register check that the clock is stretched, not overrun. Clocks sent after a master NACK catch a block that keeps driving data.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  localparam logic [4:0] ADR10_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_RX,
    ST_TX,
    ST_WAIT
  } slv_state_e;
endpackage

// File: rtl/i2c10_line_events.sv
module i2c10_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign rise_o  = scl_i & ~scl_q;
  assign fall_o  = ~scl_i & scl_q;
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              hi_ok_o,
  output logic              lo_ok_o,
  output logic              rd_o
);
  import i2c10_pkg::*;
  localparam int HI_W = ADDR_W - DATA_W;

  assign hi_ok_o = (byte_i[DATA_W-1 -: 5] == ADR10_PREFIX) &&
                   (byte_i[HI_W:1] == own_addr_i[ADDR_W-1:DATA_W]);
  assign lo_ok_o = (byte_i == own_addr_i[DATA_W-1:0]);
  assign rd_o    = byte_i[0];
endmodule

// File: rtl/i2c10_byte_buf.sv
module i2c10_byte_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              consume_i,
  output logic [DATA_W-1:0] tx_q_o,
  output logic              tx_empty_o,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_wr_i,
  input  logic              rx_read_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q_o     <= '0;
      tx_empty_o <= 1'b1;
    end else if (tx_load_i) begin
      tx_q_o     <= tx_data_i;
      tx_empty_o <= 1'b0;
    end else if (consume_i) begin
      tx_empty_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
    end else if (rx_wr_i) begin
      rx_data_o <= rx_byte_i;
      rx_full_o <= 1'b1;
    end else if (rx_read_i) begin
      rx_full_o <= 1'b0;
    end
  end

  p_rx_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_i |=> rx_full_o && (rx_data_o == $past(rx_byte_i)));

  p_consume_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !tx_load_i) |=> tx_empty_o);
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              mode10_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              scl_hold_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              rx_read_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              start_o,
  output logic              byte_end_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              busy_o,
  output logic              dir_tx_o
);
  import i2c10_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  slv_state_e        state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh, tx_q;
  logic              ack_ph, hold, nack, sda_out, sel, dir;
  logic              ev_rise, ev_fall, ev_start, ev_stop;
  logic              hi_ok, lo_ok, rd;
  logic              active, svc, consume, rx_wr;

  assign active = mode10_en_i & ~master_en_i;

  i2c10_line_events u_ev (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .rise_o  (ev_rise),
    .fall_o  (ev_fall),
    .start_o (ev_start),
    .stop_o  (ev_stop)
  );

  i2c10_addr_match #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_match (
    .byte_i     (sh),
    .own_addr_i (own_addr_i),
    .hi_ok_o    (hi_ok),
    .lo_ok_o    (lo_ok),
    .rd_o       (rd)
  );

  // buffer service happens only while SCL is stretched
  assign svc     = active & ~ev_start & ~ev_stop & hold;
  assign consume = svc & (state == ST_TX) & ~tx_empty_o;
  assign rx_wr   = svc & (state == ST_RX) & ~rx_full_o;

  i2c10_byte_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_data_i  (tx_data_i),
    .tx_load_i  (tx_load_i),
    .consume_i  (consume),
    .tx_q_o     (tx_q),
    .tx_empty_o (tx_empty_o),
    .rx_byte_i  (sh),
    .rx_wr_i    (rx_wr),
    .rx_read_i  (rx_read_i),
    .rx_data_o  (rx_data_o),
    .rx_full_o  (rx_full_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      nxt        <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      ack_ph     <= 1'b0;
      hold       <= 1'b0;
      nack       <= 1'b0;
      sda_out    <= 1'b0;
      sel        <= 1'b0;
      dir        <= 1'b0;
      start_o    <= 1'b0;
      byte_end_o <= 1'b0;
    end else begin
      start_o    <= 1'b0;
      byte_end_o <= 1'b0;
      if (!active) begin
        state   <= ST_IDLE;
        ack_ph  <= 1'b0;
        hold    <= 1'b0;
        sda_out <= 1'b0;
        sel     <= 1'b0;
        dir     <= 1'b0;
      end else if (ev_start) begin
        state   <= ST_ADR1;
        cnt     <= '0;
        ack_ph  <= 1'b0;
        hold    <= 1'b0;
        sda_out <= 1'b0;
      end else if (ev_stop) begin
        state   <= ST_IDLE;
        ack_ph  <= 1'b0;
        hold    <= 1'b0;
        sda_out <= 1'b0;
        sel     <= 1'b0;
        dir     <= 1'b0;
      end else if (hold) begin
        if (consume) begin
          sh      <= tx_q;
          sda_out <= ~tx_q[DATA_W-1];
          cnt     <= '0;
          hold    <= 1'b0;
        end else if (rx_wr) begin
          byte_end_o <= 1'b1;
          sda_out    <= 1'b1;
          ack_ph     <= 1'b1;
          nxt        <= ST_RX;
          hold       <= 1'b0;
        end
      end else begin
        unique case (state)
          ST_ADR1, ST_ADR2, ST_RX: begin
            if (!ack_ph) begin
              if (ev_rise) begin
                sh  <= {sh[DATA_W-2:0], sda_i};
                cnt <= cnt + 1'b1;
              end else if (ev_fall && cnt == LAST_BIT) begin
                if (state == ST_ADR1) begin
                  if (hi_ok && !rd) begin
                    sda_out <= 1'b1;
                    ack_ph  <= 1'b1;
                    nxt     <= ST_ADR2;
                  end else if (hi_ok && rd && sel) begin
                    sda_out <= 1'b1;
                    ack_ph  <= 1'b1;
                    nxt     <= ST_TX;
                    dir     <= 1'b1;
                    start_o <= 1'b1;
                  end else begin
                    state <= ST_WAIT;
                  end
                end else if (state == ST_ADR2) begin
                  if (lo_ok) begin
                    sda_out <= 1'b1;
                    ack_ph  <= 1'b1;
                    nxt     <= ST_RX;
                    sel     <= 1'b1;
                    dir     <= 1'b0;
                    start_o <= 1'b1;
                  end else begin
                    state <= ST_WAIT;
                    sel   <= 1'b0;
                    dir   <= 1'b0;
                  end
                end else begin
                  hold <= 1'b1;
                end
              end
            end else if (ev_fall) begin
              sda_out <= 1'b0;
              ack_ph  <= 1'b0;
              cnt     <= '0;
              state   <= nxt;
              if (nxt == ST_TX) hold <= 1'b1;
            end
          end
          ST_TX: begin
            if (!ack_ph) begin
              if (ev_rise) begin
                cnt <= cnt + 1'b1;
              end else if (ev_fall) begin
                if (cnt == LAST_BIT) begin
                  sda_out <= 1'b0;
                  ack_ph  <= 1'b1;
                end else begin
                  sh      <= {sh[DATA_W-2:0], 1'b0};
                  sda_out <= ~sh[DATA_W-2];
                end
              end
            end else begin
              if (ev_rise) begin
                nack <= sda_i;
              end else if (ev_fall) begin
                ack_ph     <= 1'b0;
                byte_end_o <= 1'b1;
                if (nack) state <= ST_WAIT;
                else      hold  <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = sda_out;
  assign scl_hold_o = hold;
  assign busy_o     = sel;
  assign dir_tx_o   = dir;

  p_inactive_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> !sda_pull_o && !scl_hold_o);

  p_select_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> start_o);

  p_dir_needs_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_tx_o |-> busy_o);

  p_stop_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_stop |=> !busy_o && !dir_tx_o);
endmodule

// File: tb/i2c10_slave_tb.sv
module i2c10_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [9:0] OWN = 10'h2A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic       mode10_en = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic       rx_read = 1'b0;
  logic       sda_pull, scl_hold, start_p, bend_p, rx_full, tx_empty, busy, dir_tx;
  logic [7:0] rx_data;
  logic       scl_line, sda_line;
  int         n_chk = 0, n_err = 0, n_start = 0, n_bend = 0;
  logic       pull_seen = 1'b0;
  logic       done = 1'b0;

  assign scl_line = scl_m & ~scl_hold;
  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c10_slave u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .master_en_i (master_en),
    .mode10_en_i (mode10_en),
    .own_addr_i  (OWN),
    .scl_i       (scl_line),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .scl_hold_o  (scl_hold),
    .tx_data_i   (tx_data),
    .tx_load_i   (tx_load),
    .rx_read_i   (rx_read),
    .rx_data_o   (rx_data),
    .start_o     (start_p),
    .byte_end_o  (bend_p),
    .rx_full_o   (rx_full),
    .tx_empty_o  (tx_empty),
    .busy_o      (busy),
    .dir_tx_o    (dir_tx)
  );

  always @(negedge clk) begin
    if (start_p) n_start++;
    if (bend_p) n_bend++;
    if (sda_pull) pull_seen = 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic send_start();
    sda_m = 1'b1; wq();
    scl_up(); wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic send_stop();
    sda_m = 1'b0; wq();
    scl_up(); wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl_up(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
  endtask

  task automatic get_ack(output logic a);
    sda_m = 1'b1; wq();
    scl_up(); wq();
    a = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic xfer_w(input logic [7:0] b, output logic a);
    put_byte(b);
    get_ack(a);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic m_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wq();
      scl_up(); wq();
      b = {b[6:0], sda_line};
      scl_m = 1'b0; wq();
    end
    sda_m = ~m_ack; wq();
    scl_up(); wq();
    scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic pulse_read();
    rx_read = 1'b1; @(negedge clk);
    rx_read = 1'b0; @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] d);
    tx_data = d; tx_load = 1'b1; @(negedge clk);
    tx_load = 1'b0; @(negedge clk);
  endtask

  function automatic logic [7:0] first_byte(input logic [4:0] pre, input logic [1:0] hi, input logic rw);
    return {pre, hi, rw};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic       a;
    logic [7:0] b;
    int         s0, e0;
    logic [4:0] pres [3];
    logic [7:0] bad_lo [4];
    logic [7:0] dat [4];
    pres[0] = 5'b11110; pres[1] = 5'b11111; pres[2] = 5'b01110;
    bad_lo[0] = 8'hA4; bad_lo[1] = 8'h25; bad_lo[2] = 8'h00; bad_lo[3] = 8'hFF;
    dat[0] = 8'h00; dat[1] = 8'hFF; dat[2] = 8'h5A; dat[3] = 8'h81;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R1 reset sda_pull", sda_pull, 0);
    chk("R1 reset scl_hold", scl_hold, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset dir", dir_tx, 0);
    chk("R5 reset rx_full", rx_full, 0);
    chk("R9 reset tx_empty", tx_empty, 1);

    // R2: first-byte sweep over prefix and upper bits
    for (int p = 0; p < 3; p++) begin
      for (int h = 0; h < 4; h++) begin
        send_start();
        xfer_w(first_byte(pres[p], 2'(h), 1'b0), a);
        chk($sformatf("R2 first byte ack pre=%0d hi=%0d", p, h), a,
            (p == 0 && h == int'(OWN[9:8])) ? 1 : 0);
        chk("R3 no select on first byte", busy, 0);
        send_stop();
      end
    end

    // R3: upper match, wrong low byte
    for (int k = 0; k < 4; k++) begin
      s0 = n_start;
      send_start();
      xfer_w(first_byte(5'b11110, OWN[9:8], 1'b0), a);
      chk("R3 shared first byte acked", a, 1);
      xfer_w(bad_lo[k], a);
      chk("R3 low mismatch nack", a, 0);
      chk("R3 low mismatch busy", busy, 0);
      chk("R3 low mismatch no start", n_start - s0, 0);
      send_stop();
    end

    // R8: read request without prior full match
    send_start();
    xfer_w(first_byte(5'b11110, OWN[9:8], 1'b1), a);
    chk("R8 read w/o match nack", a, 0);
    chk("R8 read w/o match dir", dir_tx, 0);
    send_stop();

    // R4: full match
    s0 = n_start;
    send_start();
    xfer_w(first_byte(5'b11110, OWN[9:8], 1'b0), a);
    xfer_w(OWN[7:0], a);
    chk("R4 low match ack", a, 1);
    chk("R4 busy set", busy, 1);
    chk("R4 dir receive", dir_tx, 0);
    chk("R4 start pulse", n_start - s0, 1);

    // R5: data bytes
    for (int k = 0; k < 4; k++) begin
      e0 = n_bend;
      xfer_w(dat[k], a);
      chk("R5 data ack", a, 1);
      chk("R5 rx_data", rx_data, dat[k]);
      chk("R5 rx_full", rx_full, 1);
      chk("R5 byte_end pulse", n_bend - e0, 1);
      pulse_read();
      chk("R5 rx_full cleared by read", rx_full, 0);
    end

    // R6: unread byte stretches the clock
    xfer_w(8'hC3, a);
    put_byte(8'h3C);
    repeat (6) @(negedge clk);
    chk("R6 hold while full", scl_hold, 1);
    chk("R6 old byte kept", rx_data, 8'hC3);
    chk("R6 no ack while held", sda_pull, 0);
    pulse_read();
    @(negedge clk);
    chk("R6 hold released", scl_hold, 0);
    chk("R6 new byte copied", rx_data, 8'h3C);
    get_ack(a);
    chk("R6 ack after read", a, 1);
    pulse_read();

    // R7: repeated START with read switches to transmit
    load_tx(8'h96);
    chk("R9 tx_empty cleared by load", tx_empty, 0);
    s0 = n_start;
    send_start();
    xfer_w(first_byte(5'b11110, OWN[9:8], 1'b1), a);
    chk("R7 read ack", a, 1);
    chk("R7 dir transmit", dir_tx, 1);
    chk("R7 start pulse", n_start - s0, 1);
    chk("R7 busy kept", busy, 1);
    chk("R9 tx consumed", tx_empty, 1);
    e0 = n_bend;
    get_byte(b, 1'b1);
    chk("R7 first tx byte", b, 8'h96);
    chk("R7 byte_end on tx", n_bend - e0, 1);
    repeat (4) @(negedge clk);
    chk("R9 hold when empty", scl_hold, 1);
    load_tx(8'h4B);
    @(negedge clk);
    chk("R9 hold released after load", scl_hold, 0);
    get_byte(b, 1'b0);
    chk("R7 second tx byte", b, 8'h4B);

    // R10: after master NACK, no drive
    pull_seen = 1'b0;
    for (int i = 0; i < 9; i++) put_bit(1'b1);
    chk("R10 no drive after nack", pull_seen, 0);
    chk("R10 no hold after nack", scl_hold, 0);

    // R11: STOP clears selection
    send_stop();
    chk("R11 busy cleared", busy, 0);
    chk("R11 dir cleared", dir_tx, 0);

    // R1: inactive modes
    mode10_en = 1'b0;
    pull_seen = 1'b0;
    send_start();
    xfer_w(first_byte(5'b11110, OWN[9:8], 1'b0), a);
    xfer_w(OWN[7:0], a);
    chk("R1 mode10 off no drive", pull_seen, 0);
    chk("R1 mode10 off busy", busy, 0);
    send_stop();
    mode10_en = 1'b1;
    master_en = 1'b1;
    pull_seen = 1'b0;
    send_start();
    xfer_w(first_byte(5'b11110, OWN[9:8], 1'b0), a);
    xfer_w(OWN[7:0], a);
    chk("R1 master on no drive", pull_seen, 0);
    chk("R1 master on hold", scl_hold, 0);
    send_stop();
    master_en = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule